// File: doc/BRIEF.md
# I2C Target Front End for a Byte-Addressed Memory

This block lets an I2C controller read and write a 32K x 8 synchronous RAM that sits outside it. It runs on a fast system clock that oversamples the serial clock and data lines. It recognises start and stop conditions and decodes the address byte. That byte carries a fixed type nibble, three strap-pin bits and a direction bit. The block then drives SDA only through a pull-low enable, so the bus stays open-drain.

A write transaction carries two address bytes and then any number of data bytes. Each data byte goes to the RAM at the address held in an internal counter, and the counter then steps forward. A read transaction streams bytes from the counter address for as long as the controller acknowledges. The counter wraps at the top of the 15-bit space and keeps its value between transactions. A bare read therefore continues from the byte after the last one accessed. A random read is an address-only write followed by a repeated start with the read bit set. A write-protect input stops every RAM write, but the protocol and all reads carry on as normal.

Top module: `i2c_byte_mem_target`

## Requirements
- R1: After reset, SDA is released, neither RAM strobe is active, and the address counter output is 0x0000.
- R2: The block acknowledges the address byte only when bits 7..4 equal 1010 and bits 3..1 equal the strap inputs [2:1:0]. Bit 0 selects the direction: 0 means write and 1 means read. On any mismatch the block leaves SDA released in the ninth clock and returns to idle.
- R3: In a write, the block acknowledges the next two bytes as the address, high byte first. Bit 7 of the high byte is ignored, and the remaining 15 bits load the counter.
- R4: Each further write byte is acknowledged and stored by a one-cycle write strobe at the counter address. The counter then increases by one.
- R5: The counter wraps from 0x7FFF to 0x0000, for both writes and reads.
- R6: A read that starts right after a stop returns the byte that follows the last byte accessed.
- R7: An address-only write, then a repeated start with the read bit set, returns data from the loaded address.
- R8: A read keeps sending successive bytes while the controller acknowledges, most significant bit first. After a NACK, the block releases SDA and goes idle, with the counter pointing just past the last byte sent.
- R9: While the write-protect input is high, write data bytes are still acknowledged but no write strobe is issued. Reads still work.
- R10: A stop before the acknowledge bit of a data byte aborts that byte. No write takes place and the counter keeps its value.
- R11: A start or repeated start at any point, even in the middle of a byte, restarts reception of the address byte.
- R12: The pull-low enable is only ever asserted while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data level read from the bus |
| sda_pull_o | output | 1 | When high, the bus pulls SDA low |
| strap_i | input | 3 | Address strap pins, matched against address byte bits 3..1 |
| wp_i | input | 1 | Write protect; high blocks all RAM writes |
| mem_addr_o | output | 15 | RAM address (the address counter) |
| mem_wdata_o | output | 8 | RAM write data |
| mem_we_o | output | 1 | One-cycle RAM write strobe |
| mem_re_o | output | 1 | One-cycle RAM read strobe; data is expected one cycle later |
| mem_rdata_i | input | 8 | RAM read data |

## Verification
Most internal faults show up at the pins within one byte time. A wrong state decode shows up as an acknowledge in the wrong ninth clock, or a missing one. A bit-counter slip shifts the read data on SDA by one position. A bad counter update shows up on mem_addr_o right after a strobe, and again in the data returned by the next read. A fault in write protect or in stop-abort handling appears as a write strobe that should not exist. The bench also sees the missing write when it reads back the model RAM. Faults in wraparound and in counter retention only appear once the next transaction starts. So the bench follows each write sequence with a read that depends on where the counter was left.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK
    } tgt_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [STAGES:0] scl_chain;
    logic [STAGES:0] sda_chain;
    logic            scl_prev_q;
    logic            sda_prev_q;

    assign scl_chain[0] = scl_i;
    assign sda_chain[0] = sda_i;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic scl_st_q;
        logic sda_st_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                scl_st_q <= 1'b1;
                sda_st_q <= 1'b1;
            end else begin
                scl_st_q <= scl_chain[s];
                sda_st_q <= sda_chain[s];
            end
        end
        assign scl_chain[s+1] = scl_st_q;
        assign sda_chain[s+1] = sda_st_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_chain[STAGES];
            sda_prev_q <= sda_chain[STAGES];
        end
    end

    assign scl_o      = scl_chain[STAGES];
    assign sda_o      = sda_chain[STAGES];
    assign scl_rise_o = scl_o & ~scl_prev_q;
    assign scl_fall_o = ~scl_o & scl_prev_q;
    assign start_o    = scl_o & scl_prev_q & sda_prev_q & ~sda_o;
    assign stop_o     = scl_o & scl_prev_q & ~sda_prev_q & sda_o;

endmodule

// File: rtl/i2c_dev_match.sv
module i2c_dev_match #(
    parameter logic [3:0]  TYPE_CODE = 4'b1010,
    parameter int unsigned STRAP_W   = 3
) (
    input  logic [7:0]         dev_byte_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               hit_o,
    output logic               is_read_o
);

    localparam int unsigned STRAP_LSB = 1;

    always_comb begin
        hit_o     = (dev_byte_i[7:4] == TYPE_CODE) &&
                    (dev_byte_i[STRAP_LSB +: STRAP_W] == strap_i);
        is_read_o = dev_byte_i[0];
    end

endmodule

// File: rtl/i2c_addr_ctr.sv
module i2c_addr_ctr #(
    parameter int unsigned AW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] load_val_i,
    input  logic          inc_i,
    output logic [AW-1:0] addr_o
);

    logic [AW-1:0] cnt_d;
    logic [AW-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (inc_i) begin
            cnt_d = cnt_q + AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign addr_o = cnt_q;

endmodule

// File: rtl/i2c_byte_mem_target.sv
module i2c_byte_mem_target
    import i2c_mem_pkg::*;
#(
    parameter int unsigned AW          = 15,
    parameter int unsigned STRAP_W     = 3,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [3:0]  TYPE_CODE   = 4'b1010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_pull_o,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               wp_i,
    output logic [AW-1:0]      mem_addr_o,
    output logic [BYTE_W-1:0]  mem_wdata_o,
    output logic               mem_we_o,
    output logic               mem_re_o,
    input  logic [BYTE_W-1:0]  mem_rdata_i
);

    localparam int unsigned HI_W  = AW - BYTE_W;
    localparam int unsigned CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        tgt_state_e        state;
        tgt_state_e        ret;
        logic [CNT_W-1:0]  bitcnt;
        logic [BYTE_W-1:0] shreg;
        logic              full;
        logic [HI_W-1:0]   hi;
        logic              pull;
        logic              we;
        logic              re;
        logic              cap;
        logic              more;
        logic              ld;
        logic [AW-1:0]     ld_val;
    } regs_t;

    regs_t r_d;
    regs_t r_q;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic dev_hit, dev_rd;
    logic [AW-1:0] ctr;

    i2c_line_sync #(
        .STAGES(SYNC_STAGES)
    ) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_o     (scl_s),
        .sda_o     (sda_s),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall),
        .start_o   (start_det),
        .stop_o    (stop_det)
    );

    i2c_dev_match #(
        .TYPE_CODE(TYPE_CODE),
        .STRAP_W  (STRAP_W)
    ) match_i (
        .dev_byte_i(r_q.shreg),
        .strap_i   (strap_i),
        .hit_o     (dev_hit),
        .is_read_o (dev_rd)
    );

    i2c_addr_ctr #(
        .AW(AW)
    ) ctr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (r_q.ld),
        .load_val_i(r_q.ld_val),
        .inc_i     (r_q.we | r_q.re),
        .addr_o    (ctr)
    );

    always_comb begin
        r_d     = r_q;
        r_d.we  = 1'b0;
        r_d.re  = 1'b0;
        r_d.ld  = 1'b0;
        r_d.cap = r_q.re;
        if (r_q.cap) begin
            r_d.shreg = mem_rdata_i;
        end

        case (r_q.state)
            ST_DEV, ST_ADDR_HI, ST_ADDR_LO, ST_WDATA: begin
                if (scl_rise) begin
                    r_d.shreg  = {r_q.shreg[BYTE_W-2:0], sda_s};
                    r_d.bitcnt = r_q.bitcnt + CNT_W'(1);
                    if (r_q.bitcnt == LAST_BIT) begin
                        r_d.full = 1'b1;
                    end
                end else if (scl_fall && r_q.full) begin
                    r_d.full   = 1'b0;
                    r_d.bitcnt = '0;
                    r_d.state  = ST_ACK;
                    r_d.pull   = 1'b1;
                    case (r_q.state)
                        ST_DEV: begin
                            if (!dev_hit) begin
                                r_d.state = ST_IDLE;
                                r_d.pull  = 1'b0;
                            end else if (dev_rd) begin
                                r_d.ret = ST_RDATA;
                                r_d.re  = 1'b1;
                            end else begin
                                r_d.ret = ST_ADDR_HI;
                            end
                        end
                        ST_ADDR_HI: begin
                            r_d.hi  = r_q.shreg[HI_W-1:0];
                            r_d.ret = ST_ADDR_LO;
                        end
                        ST_ADDR_LO: begin
                            r_d.ld     = 1'b1;
                            r_d.ld_val = {r_q.hi, r_q.shreg};
                            r_d.ret    = ST_WDATA;
                        end
                        default: begin
                            r_d.we  = ~wp_i;
                            r_d.ret = ST_WDATA;
                        end
                    endcase
                end
            end

            ST_ACK: begin
                if (scl_fall) begin
                    r_d.bitcnt = '0;
                    r_d.state  = r_q.ret;
                    r_d.pull   = (r_q.ret == ST_RDATA) ? ~r_q.shreg[BYTE_W-1] : 1'b0;
                end
            end

            ST_RDATA: begin
                if (scl_fall) begin
                    if (r_q.bitcnt == LAST_BIT) begin
                        r_d.state = ST_RACK;
                        r_d.pull  = 1'b0;
                    end else begin
                        r_d.shreg  = {r_q.shreg[BYTE_W-2:0], 1'b0};
                        r_d.bitcnt = r_q.bitcnt + CNT_W'(1);
                        r_d.pull   = ~r_q.shreg[BYTE_W-2];
                    end
                end
            end

            ST_RACK: begin
                if (scl_rise) begin
                    r_d.more = ~sda_s;
                    r_d.re   = ~sda_s;
                end else if (scl_fall) begin
                    if (r_q.more) begin
                        r_d.state  = ST_RDATA;
                        r_d.bitcnt = '0;
                        r_d.pull   = ~r_q.shreg[BYTE_W-1];
                    end else begin
                        r_d.state = ST_IDLE;
                    end
                end
            end

            default: begin
            end
        endcase

        if (start_det) begin
            r_d.state  = ST_DEV;
            r_d.bitcnt = '0;
            r_d.full   = 1'b0;
            r_d.pull   = 1'b0;
        end else if (stop_det) begin
            r_d.state = ST_IDLE;
            r_d.full  = 1'b0;
            r_d.pull  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, ret: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_pull_o  = r_q.pull;
    assign mem_addr_o  = ctr;
    assign mem_wdata_o = r_q.shreg;
    assign mem_we_o    = r_q.we;
    assign mem_re_o    = r_q.re;

    // R9
    wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> !$past(wp_i));

    // R4
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> !mem_we_o);

    // R5
    ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o || mem_re_o) && !r_q.ld |=> mem_addr_o == $past(mem_addr_o) + AW'(1));

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && mem_re_o));

    // R11
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (r_q.state == ST_DEV) && !sda_pull_o);

    // R10
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (r_q.state == ST_IDLE) && !sda_pull_o);

    // R12
    pull_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_s);

endmodule

// File: tb/i2c_byte_mem_target_tb_top.sv
`timescale 1ns/1ps
module i2c_byte_mem_target_tb_top;

    localparam int AW  = 15;
    localparam int QTR = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic wp = 1'b0;
    logic [2:0] strap = 3'b101;
    logic sda_pull;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata;
    logic mem_we, mem_re;
    logic [7:0] mem_rdata = 8'h00;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    int wcount = 0;
    int r12_viol = 0;
    bit done = 1'b0;

    logic [7:0] ram_m [int];
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] rx_byte;
    event       rx_ev;

    always #10 clk = ~clk;

    assign sda_line = sda_drv & ~sda_pull;

    i2c_byte_mem_target dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_drv),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull),
        .strap_i    (strap),
        .wp_i       (wp),
        .mem_addr_o (mem_addr),
        .mem_wdata_o(mem_wdata),
        .mem_we_o   (mem_we),
        .mem_re_o   (mem_re),
        .mem_rdata_i(mem_rdata)
    );

    function automatic logic [7:0] peek(input int a);
        if (ram_m.exists(a)) return ram_m[a];
        return 8'(a) ^ 8'(a >> 8) ^ 8'h5C;
    endfunction

    always @(posedge clk) begin
        if (mem_re) mem_rdata <= peek(int'(mem_addr));
        if (mem_we) begin
            ram_m[int'(mem_addr)] = mem_wdata;
            wcount++;
        end
    end

    logic pull_prev = 1'b0;
    always @(posedge clk) begin
        if (sda_pull && !pull_prev && scl_drv) r12_viol++;
        pull_prev <= sda_pull;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(rx_ev);
            if (exp_q.size() == 0) begin
                chk(1'b0, "scoreboard-underflow", int'(rx_byte), 0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rx_byte == e, t, int'(rx_byte), int'(e));
            end
        end
    end

    task automatic qw();
        repeat (QTR) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; qw();
        scl_drv = 1'b1; qw();
        sda_drv = 1'b0; qw();
        scl_drv = 1'b0; qw();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; qw();
        scl_drv = 1'b1; qw();
        sda_drv = 1'b1; qw();
        qw();
    endtask

    task automatic clk_bit(input bit b, output bit seen);
        sda_drv = b; qw();
        scl_drv = 1'b1; qw();
        seen = sda_line; qw();
        scl_drv = 1'b0; qw();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        bit s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(input bit host_ack, input logic [7:0] e, input string tag);
        bit s;
        logic [7:0] v = 8'h00;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, s);
            v = {v[6:0], s};
        end
        clk_bit(!host_ack, s);
        sda_drv = 1'b1;
        rx_byte = v;
        ->rx_ev;
        #1;
    endtask

    task automatic send_addr(input int a, input logic [7:0] hi_extra);
        bit ack;
        send_byte(8'(a >> 8) | hi_extra, ack);
        chk(ack, "R3 high address ack", int'(ack), 1);
        send_byte(8'(a), ack);
        chk(ack, "R3 low address ack", int'(ack), 1);
    endtask

    initial begin
        bit ack;
        int w0;
        repeat (4) @(posedge clk);
        #1;
        // R1 reset state
        chk(sda_pull == 1'b0, "R1 sda released", int'(sda_pull), 0);
        chk(mem_we == 1'b0 && mem_re == 1'b0, "R1 strobes idle", int'({mem_we, mem_re}), 0);
        chk(mem_addr == '0, "R1 counter zero", int'(mem_addr), 0);
        rst_n = 1'b1;
        qw();

        // R2 wrong type code and wrong strap
        bus_start(); send_byte(8'h9A, ack);
        chk(!ack, "R2 type mismatch no ack", int'(ack), 0);
        bus_stop();
        bus_start(); send_byte(8'hA2, ack);
        chk(!ack, "R2 strap mismatch no ack", int'(ack), 0);
        bus_stop();

        // R3 R4 write burst, high bit 7 set and ignored
        bus_start(); send_byte(8'hAA, ack);
        chk(ack, "R2 match ack", int'(ack), 1);
        send_addr(32'h0123, 8'h80);
        send_byte(8'h11, ack); chk(ack, "R4 data ack", int'(ack), 1);
        send_byte(8'h22, ack); chk(ack, "R4 data ack", int'(ack), 1);
        send_byte(8'h33, ack); chk(ack, "R4 data ack", int'(ack), 1);
        bus_stop();
        chk(peek(32'h0123) == 8'h11, "R3 stored at loaded address", int'(peek(32'h0123)), 8'h11);
        chk(peek(32'h0125) == 8'h33, "R4 burst stored", int'(peek(32'h0125)), 8'h33);
        chk(mem_addr == 15'h0126, "R4 counter after burst", int'(mem_addr), 32'h126);

        // R6 current-address read, R8 release after NACK
        bus_start(); send_byte(8'hAB, ack);
        chk(ack, "R2 read ack", int'(ack), 1);
        recv_byte(1'b0, peek(32'h0126), "R6 current address data");
        chk(sda_pull == 1'b0, "R8 released after nack", int'(sda_pull), 0);
        chk(mem_addr == 15'h0127, "R8 counter past last", int'(mem_addr), 32'h127);
        bus_stop();

        // R7 random read, R8 sequential
        bus_start(); send_byte(8'hAA, ack);
        send_addr(32'h0124, 8'h00);
        bus_start(); send_byte(8'hAB, ack);
        chk(ack, "R7 repeated start ack", int'(ack), 1);
        recv_byte(1'b1, 8'h22, "R7 random read data");
        recv_byte(1'b1, 8'h33, "R8 sequential byte 2");
        recv_byte(1'b0, peek(32'h0126), "R8 sequential byte 3");
        bus_stop();

        // R5 wraparound on write and read
        bus_start(); send_byte(8'hAA, ack);
        send_addr(32'h7FFF, 8'h00);
        send_byte(8'hA5, ack);
        send_byte(8'h5A, ack);
        bus_stop();
        chk(peek(32'h7FFF) == 8'hA5, "R5 top byte", int'(peek(32'h7FFF)), 8'hA5);
        chk(peek(0) == 8'h5A, "R5 write wrapped to zero", int'(peek(0)), 8'h5A);
        chk(mem_addr == 15'h0001, "R5 counter wrapped", int'(mem_addr), 1);
        bus_start(); send_byte(8'hAA, ack);
        send_addr(32'h7FFE, 8'h00);
        bus_start(); send_byte(8'hAB, ack);
        recv_byte(1'b1, peek(32'h7FFE), "R5 read before top");
        recv_byte(1'b1, 8'hA5, "R5 read top");
        recv_byte(1'b0, 8'h5A, "R5 read wrapped");
        bus_stop();

        // R9 write protect
        wp = 1'b1;
        w0 = wcount;
        bus_start(); send_byte(8'hAA, ack);
        send_addr(32'h0200, 8'h00);
        send_byte(8'h77, ack);
        chk(ack, "R9 protected data still acked", int'(ack), 1);
        bus_stop();
        chk(wcount == w0, "R9 no write strobe", wcount, w0);
        bus_start(); send_byte(8'hAA, ack);
        send_addr(32'h0200, 8'h00);
        bus_start(); send_byte(8'hAB, ack);
        recv_byte(1'b0, peek(32'h0200), "R9 read under protect unchanged");
        bus_stop();
        wp = 1'b0;

        // R10 stop inside data byte
        w0 = wcount;
        bus_start(); send_byte(8'hAA, ack);
        send_addr(32'h0300, 8'h00);
        for (int i = 0; i < 4; i++) begin
            bit s;
            clk_bit(1'b0, s);
        end
        bus_stop();
        chk(wcount == w0, "R10 aborted byte not written", wcount, w0);
        chk(mem_addr == 15'h0300, "R10 counter kept", int'(mem_addr), 32'h300);

        // R11 restart in the middle of the address byte
        bus_start();
        for (int i = 0; i < 3; i++) begin
            bit s;
            clk_bit(1'b1, s);
        end
        bus_start(); send_byte(8'hAB, ack);
        chk(ack, "R11 restart mid byte ack", int'(ack), 1);
        recv_byte(1'b0, peek(32'h0300), "R11 read after restart");
        bus_stop();

        // R12 pull only rises with SCL low
        chk(r12_viol == 0, "R12 pull asserted with SCL high", r12_viol, 0);
        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule